// File: doc/BRIEF.md
# Incremental PID Controller with Anti-Windup

This block is a discrete PID regulator in velocity form. Each accepted sample strobe adds the changes from the proportional, integral and filtered derivative terms to a stored pre-limit output, adds the feed-forward value, and limits the result to a programmable window. The integral change is dropped while the stored output plus the feed-forward sits on or past either limit. This is conditional-integration anti-windup. A load input writes the stored output directly, so a loop can take over from an open-loop drive value without a bump.

All data values (set point, measurement, feed-forward, limits, load value, output) are signed DW-bit integers in one common scale. Coefficients are signed CW-bit fixed point with CF fraction bits, so 1.0 is 2^CF. The host precomputes them: the proportional gain, the integral gain times the sample period, and the derivative gain over the sample period. The derivative low-pass is set by a keep weight and a new-sample weight. Every product is shifted right arithmetically by CF, which rounds toward minus infinity. Products and internal sums saturate to IW = DW + GUARD bits. Inputs other than the strobe must stay stable from the strobe until the valid pulse.

The control FSM has four states. ST_IDLE waits and either takes a load or, on a strobe, captures the error and the feed-forward, then moves to ST_TERMS. ST_TERMS registers the three raw terms and moves to ST_FILT. ST_FILT registers the filtered derivative and moves to ST_COMMIT. ST_COMMIT updates the histories and the output, pulses valid, and returns to ST_IDLE. Every transition out of the three busy states is unconditional.

Top module: `pid_incr_ctrl`

## Requirements
- R1: The error is set point minus measurement. The proportional change is sat((k_prop·(e[n]−e[n−1])) >>> CF).
- R2: The integral change is sat((k_int·e[n]) >>> CF). It is zero when stored output plus feed-forward is ≥ lim_hi or ≤ lim_lo.
- R3: The raw derivative is sat((k_der·(e[n]−2e[n−1]+e[n−2])) >>> CF). The filtered value is sat(sat((f_keep·d_prev)>>>CF) + sat((f_new·raw)>>>CF)). With f_keep=0 and f_new=2^CF (zero time constant) it passes the raw value unchanged.
- R4: The new stored output is sat(stored + P + I + filtered D), which excludes feed-forward. The pre-limit output is sat(new stored + feed-forward).
- R5: ctrl_out is the pre-limit output clamped to [lim_lo, lim_hi].
- R6: After each update e[n−1] moves to e[n−2], the current error becomes e[n−1], and the filtered derivative becomes the filter state.
- R7: A strobe accepted in ST_IDLE at clock edge k sets ctrl_valid for exactly the one cycle after edge k+3, and ctrl_out changes at that edge.
- R8: A strobe seen while the FSM is not in ST_IDLE is ignored and starts no extra update.
- R9: load_en in ST_IDLE writes load_val into the stored output and takes priority over a strobe in the same cycle, which is dropped.
- R10: Reset (synchronous, active high) clears the error history, the filter state, ctrl_out and ctrl_valid. It clears the stored output too, unless load_en is high during reset, in which case the stored output takes load_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Start one update |
| load_en | input | 1 | Write load_val into the stored output |
| load_val | input | DW | Open-loop value for bumpless start |
| setpoint | input | DW | Desired value |
| measure | input | DW | Measured plant output |
| feedfwd | input | DW | Feed-forward added to the output |
| k_prop | input | CW | Proportional gain |
| k_int | input | CW | Integral gain times sample period |
| k_der | input | CW | Derivative gain over sample period |
| f_keep | input | CW | Filter weight on the previous filtered value |
| f_new | input | CW | Filter weight on the raw derivative |
| lim_lo | input | DW | Lower output limit |
| lim_hi | input | DW | Upper output limit |
| ctrl_out | output | DW | Clamped control output |
| ctrl_valid | output | 1 | One-cycle pulse when ctrl_out is updated |

## Verification
The hardest condition to reach is the anti-windup decision. The stored output is not visible at the ports, and it must sit at or beyond a limit once the feed-forward is added. The bench preloads the stored output next to a narrow limit window and applies a feed-forward that crosses the limit. It then takes a second sample with zero error and a large negative feed-forward. That sample brings the stored value back inside the window, where it can be compared with and without integration. Randomized runs use narrow random limits and feed-forward values so that the condition also arises against the error history.

// File: rtl/pid_pkg.sv
package pid_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TERMS  = 2'd1,
        ST_FILT   = 2'd2,
        ST_COMMIT = 2'd3
    } pid_state_e;
endpackage

// File: rtl/pid_scaled_mul.sv
// Signed product, arithmetic right shift by CF, saturated to OW bits.
module pid_scaled_mul #(
    parameter int XW = 19,
    parameter int CW = 16,
    parameter int CF = 12,
    parameter int OW = 20
) (
    input  logic signed [XW-1:0] x,
    input  logic signed [CW-1:0] c,
    output logic signed [OW-1:0] y
);
    localparam int PW = XW + CW;
    localparam logic signed [PW-1:0] PMAX = {{(PW-OW+1){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [PW-1:0] PMIN = ~PMAX;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;

    always_comb begin
        prod = PW'(x) * PW'(c);
        shf  = prod >>> CF;
        if (shf > PMAX)
            y = PMAX[OW-1:0];
        else if (shf < PMIN)
            y = PMIN[OW-1:0];
        else
            y = shf[OW-1:0];
    end
endmodule

// File: rtl/pid_out_clamp.sv
// Limits a wide internal value to the [lo, hi] window.
module pid_out_clamp #(
    parameter int IW = 20,
    parameter int DW = 16
) (
    input  logic signed [IW-1:0] x,
    input  logic signed [DW-1:0] lo,
    input  logic signed [DW-1:0] hi,
    output logic signed [DW-1:0] y
);
    logic signed [IW-1:0] lo_w;
    logic signed [IW-1:0] hi_w;

    always_comb begin
        lo_w = IW'(lo);
        hi_w = IW'(hi);
        if (x >= hi_w)
            y = hi;
        else if (x <= lo_w)
            y = lo;
        else
            y = x[DW-1:0];
    end
endmodule

// File: rtl/pid_incr_ctrl.sv
module pid_incr_ctrl
    import pid_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = 16,
    parameter int CF    = 12,
    parameter int GUARD = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_stb,
    input  logic                 load_en,
    input  logic signed [DW-1:0] load_val,
    input  logic signed [DW-1:0] setpoint,
    input  logic signed [DW-1:0] measure,
    input  logic signed [DW-1:0] feedfwd,
    input  logic signed [CW-1:0] k_prop,
    input  logic signed [CW-1:0] k_int,
    input  logic signed [CW-1:0] k_der,
    input  logic signed [CW-1:0] f_keep,
    input  logic signed [CW-1:0] f_new,
    input  logic signed [DW-1:0] lim_lo,
    input  logic signed [DW-1:0] lim_hi,
    output logic signed [DW-1:0] ctrl_out,
    output logic                 ctrl_valid
);
    localparam int EW = DW + 1;      // error width
    localparam int IW = DW + GUARD;  // internal width
    localparam int SW = IW + 3;      // sum width before saturation
    localparam logic signed [SW-1:0] SMAX = {{4{1'b0}}, {(IW-1){1'b1}}};
    localparam logic signed [SW-1:0] SMIN = ~SMAX;

    function automatic logic signed [IW-1:0] sat_iw(input logic signed [SW-1:0] v);
        if (v > SMAX)
            return SMAX[IW-1:0];
        else if (v < SMIN)
            return SMIN[IW-1:0];
        else
            return v[IW-1:0];
    endfunction

    pid_state_e state, state_nx;

    logic signed [EW-1:0] e_cur, e_p1, e_p2;
    logic signed [DW-1:0] ff_r;
    logic signed [IW-1:0] p_r, i_r, d_raw, d_filt, d_prev, u_prev;

    logic signed [EW:0]   diff1;
    logic signed [EW+1:0] diff2;
    logic signed [EW-1:0] err_in;
    logic signed [IW-1:0] p_m, i_m, d_m, fa_m, fb_m;
    logic signed [IW-1:0] filt_sum, core_sum, full_sum;
    logic signed [DW-1:0] clamped;
    logic signed [SW-1:0] guard_sum;
    logic                 windup;

    // error and differences
    always_comb begin
        err_in = EW'(setpoint) - EW'(measure);
        diff1  = (EW+1)'(e_cur) - (EW+1)'(e_p1);
        diff2  = (EW+2)'(e_cur) - ((EW+2)'(e_p1) <<< 1) + (EW+2)'(e_p2);
    end

    pid_scaled_mul #(.XW(EW+1), .CW(CW), .CF(CF), .OW(IW)) u_mul_p
        (.x(diff1), .c(k_prop), .y(p_m));
    pid_scaled_mul #(.XW(EW),   .CW(CW), .CF(CF), .OW(IW)) u_mul_i
        (.x(e_cur), .c(k_int),  .y(i_m));
    pid_scaled_mul #(.XW(EW+2), .CW(CW), .CF(CF), .OW(IW)) u_mul_d
        (.x(diff2), .c(k_der),  .y(d_m));
    pid_scaled_mul #(.XW(IW),   .CW(CW), .CF(CF), .OW(IW)) u_mul_fa
        (.x(d_prev), .c(f_keep), .y(fa_m));
    pid_scaled_mul #(.XW(IW),   .CW(CW), .CF(CF), .OW(IW)) u_mul_fb
        (.x(d_raw),  .c(f_new),  .y(fb_m));

    // sums and anti-windup decision
    always_comb begin
        guard_sum = SW'(u_prev) + SW'(ff_r);
        windup    = (guard_sum >= SW'(lim_hi)) || (guard_sum <= SW'(lim_lo));
        filt_sum  = sat_iw(SW'(fa_m) + SW'(fb_m));
        core_sum  = sat_iw(SW'(u_prev) + SW'(p_r) + SW'(i_r) + SW'(d_filt));
        full_sum  = sat_iw(SW'(core_sum) + SW'(ff_r));
    end

    pid_out_clamp #(.IW(IW), .DW(DW)) u_clamp
        (.x(full_sum), .lo(lim_lo), .hi(lim_hi), .y(clamped));

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = (sample_stb && !load_en) ? ST_TERMS : ST_IDLE;
            ST_TERMS:  state_nx = ST_FILT;
            ST_FILT:   state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            e_cur      <= '0;
            e_p1       <= '0;
            e_p2       <= '0;
            ff_r       <= '0;
            p_r        <= '0;
            i_r        <= '0;
            d_raw      <= '0;
            d_filt     <= '0;
            d_prev     <= '0;
            u_prev     <= load_en ? IW'(load_val) : '0;
            ctrl_out   <= '0;
            ctrl_valid <= 1'b0;
        end else begin
            ctrl_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (load_en) begin
                        u_prev <= IW'(load_val);
                    end else if (sample_stb) begin
                        e_cur <= err_in;
                        ff_r  <= feedfwd;
                    end
                end
                ST_TERMS: begin
                    p_r   <= p_m;
                    i_r   <= windup ? '0 : i_m;
                    d_raw <= d_m;
                end
                ST_FILT: begin
                    d_filt <= filt_sum;
                end
                ST_COMMIT: begin
                    u_prev     <= core_sum;
                    ctrl_out   <= clamped;
                    ctrl_valid <= 1'b1;
                    e_p2       <= e_p1;
                    e_p1       <= e_cur;
                    d_prev     <= d_filt;
                end
                default: ;
            endcase
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |=> !ctrl_valid); // R7
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && sample_stb && !load_en) |=> ##3 ctrl_valid); // R7
    AST_OUT_IN_LIMITS: assert property (@(posedge clk) disable iff (rst)
        (ctrl_valid && lim_lo <= lim_hi) |-> (ctrl_out >= lim_lo && ctrl_out <= lim_hi)); // R5
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |-> (e_p2 == $past(e_p1) && e_p1 == $past(e_cur))); // R6
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && load_en) |=> (u_prev == IW'($past(load_val)))); // R9
endmodule

// File: tb/tb_pid_incr_ctrl.sv
module tb_pid_incr_ctrl;
    localparam int DW = 16, CW = 16, CF = 12, GUARD = 4;
    localparam int IW = DW + GUARD;
    localparam longint IMAX = (64'sd1 <<< (IW-1)) - 1;
    localparam longint IMIN = -(64'sd1 <<< (IW-1));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 1'b0, load_en = 1'b0;
    logic signed [DW-1:0] load_val = '0, setpoint = '0, measure = '0, feedfwd = '0;
    logic signed [CW-1:0] k_prop = '0, k_int = '0, k_der = '0, f_keep = '0, f_new = '0;
    logic signed [DW-1:0] lim_lo = '0, lim_hi = '0;
    logic signed [DW-1:0] ctrl_out;
    logic ctrl_valid;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // model state
    longint me1 = 0, me2 = 0, mdp = 0, mup = 0;

    always #2 clk = ~clk;

    pid_incr_ctrl #(.DW(DW), .CW(CW), .CF(CF), .GUARD(GUARD)) dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb), .load_en(load_en),
        .load_val(load_val), .setpoint(setpoint), .measure(measure),
        .feedfwd(feedfwd), .k_prop(k_prop), .k_int(k_int), .k_der(k_der),
        .f_keep(f_keep), .f_new(f_new), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .ctrl_out(ctrl_out), .ctrl_valid(ctrl_valid));

    function automatic longint msat(longint v);
        if (v > IMAX) return IMAX;
        if (v < IMIN) return IMIN;
        return v;
    endfunction

    function automatic longint mmul(longint c, longint x);
        return msat((c * x) >>> CF);
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1 R2 R3 R4 R5 R6 model for one update
    function automatic longint model_step(longint sp, longint ms, longint ff);
        longint e, p, i, dr, df, core, full, o;
        e    = sp - ms;
        p    = mmul(k_prop, e - me1);
        i    = ((mup + ff >= lim_hi) || (mup + ff <= lim_lo)) ? 0 : mmul(k_int, e);
        dr   = mmul(k_der, e - 2 * me1 + me2);
        df   = msat(mmul(f_keep, mdp) + mmul(f_new, dr));
        core = msat(mup + p + i + df);
        full = msat(core + ff);
        o    = (full >= lim_hi) ? lim_hi : (full <= lim_lo) ? lim_lo : full;
        me2 = me1; me1 = e; mdp = df; mup = core;
        return o;
    endfunction

    task automatic do_sample(string req, longint sp, longint ms, longint ff, int hold);
        longint exp;
        int lat, nvalid;
        @(negedge clk);
        setpoint = DW'(sp); measure = DW'(ms); feedfwd = DW'(ff);
        sample_stb = 1'b1;
        exp = model_step(sp, ms, ff);
        lat = 0; nvalid = 0;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k + 1 >= hold) sample_stb = 1'b0;
            if (ctrl_valid) begin
                nvalid++;
                if (nvalid == 1) begin
                    lat = k + 1;
                    chk(req, ctrl_out, exp);
                end
            end
        end
        chk("R7 latency", lat, 4);
        if (hold > 1) chk("R8 busy strobes ignored", nvalid, 1);
    endtask

    task automatic do_load(longint v);
        @(negedge clk);
        load_en = 1'b1; load_val = DW'(v);
        @(negedge clk);
        load_en = 1'b0;
        mup = v;
    endtask

    task automatic set_gains(longint kp, longint ki, longint kd, longint fa, longint fb);
        k_prop = CW'(kp); k_int = CW'(ki); k_der = CW'(kd);
        f_keep = CW'(fa); f_new = CW'(fb);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        lim_lo = -16'sd30000; lim_hi = 16'sd30000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset output", ctrl_out, 0);
        chk("R10 reset valid", ctrl_valid, 0);

        // R1 proportional only, zero time constant filter
        set_gains(4096, 0, 0, 0, 4096);
        do_sample("R1 proportional step", 500, 200, 0, 1);
        do_sample("R1 proportional hold", 500, 200, 0, 1);
        do_sample("R1 proportional negative", -100, 300, 0, 1);

        // R3 derivative with pass-through then with filtering
        set_gains(0, 0, 2048, 0, 4096);
        do_sample("R3 derivative pass-through", 1000, 0, 0, 1);
        set_gains(0, 0, 8192, 3072, 1024);
        do_sample("R3 derivative filtered", 0, 0, 0, 1);
        do_sample("R3 derivative filtered decay", 0, 0, 0, 1);

        // R9 bumpless start: zero gains reproduce the loaded value
        set_gains(0, 0, 0, 0, 4096);
        do_load(1000);
        do_sample("R9 load bumpless", 0, 0, 0, 1);
        do_sample("R4 feed-forward excluded from store", 0, 0, 50, 1);
        do_sample("R4 feed-forward removed", 0, 0, 0, 1);

        // R2 anti-windup at the upper limit
        lim_lo = -16'sd100; lim_hi = 16'sd100;
        set_gains(0, 4096, 0, 0, 4096);
        do_load(95);
        do_sample("R2 windup upper saturates", 50, 0, 10, 1);
        do_sample("R2 windup integral skipped", 0, 0, -50, 1);
        do_load(-20);
        do_sample("R2 integrating inside window", 30, 0, 0, 1);
        // R5 clamp at the lower limit
        do_sample("R5 clamp low", 0, 0, -500, 1);

        // R8 strobe held while busy
        lim_lo = -16'sd30000; lim_hi = 16'sd30000;
        set_gains(4096, 1024, 0, 0, 4096);
        do_sample("R8 held strobe result", 300, 100, 0, 3);
        do_sample("R8 next after held strobe", 300, 100, 0, 1);

        // R9 load has priority over a simultaneous strobe
        @(negedge clk);
        load_en = 1'b1; load_val = 16'sd777; sample_stb = 1'b1;
        @(negedge clk);
        load_en = 1'b0; sample_stb = 1'b0;
        mup = 777;
        repeat (5) begin
            @(negedge clk);
            chk("R9 strobe with load dropped", ctrl_valid, 0);
        end
        set_gains(0, 0, 0, 0, 4096);
        do_sample("R9 load value kept", 0, 0, 0, 1);

        // R10 reset with load asserted preloads the stored output
        @(negedge clk);
        rst = 1'b1; load_en = 1'b1; load_val = 16'sd300;
        @(negedge clk);
        rst = 1'b0; load_en = 1'b0;
        me1 = 0; me2 = 0; mdp = 0; mup = 300;
        chk("R10 reset with preload output", ctrl_out, 0);
        do_sample("R10 preload through reset", 0, 0, 0, 1);

        // randomized sequences
        for (int n = 0; n < 600; n++) begin
            longint sp, ms, ff;
            if (n % 40 == 0) begin
                longint fa;
                fa = longint'($urandom_range(0, 4095));
                set_gains(longint'($urandom_range(0, 16383)) - 8192,
                          longint'($urandom_range(0, 8191)) - 4096,
                          longint'($urandom_range(0, 8191)) - 4096,
                          fa, 4096 - fa);
                lim_lo = DW'(-longint'($urandom_range(0, 3000)));
                lim_hi = DW'(longint'($urandom_range(0, 3000)));
            end
            if (n % 97 == 5) do_load(longint'($urandom_range(0, 4000)) - 2000);
            sp = longint'($urandom_range(0, 16000)) - 8000;
            ms = longint'($urandom_range(0, 16000)) - 8000;
            ff = longint'($urandom_range(0, 2000)) - 1000;
            do_sample("R1 R2 R3 R4 R5 R6 random", sp, ms, ff, 1);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule